// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider

This block turns a single base clock into five independent tick enables, one for each channel of a five-channel PWM timer. Two 8-bit prescalers divide the base clock: the first serves channels 0 and 1, the second serves channels 2 to 4. Behind its group's prescaler, each channel has its own power-of-two divider. A channel can instead take its ticks from one of two asynchronous external tick inputs, also shared by the same channel groups.

Two configuration registers are loaded through a single-cycle write port. The prescaler register holds both prescale values. The selector register holds one 4-bit code per channel. Each output is a one-cycle enable in the base clock domain. A downstream counter uses it to advance by one step.

Top module: `pwm_tick_gen`

## Requirements
- R1: Reset clears both registers and all counters, and no tick is issued while reset is held. After reset, every channel divides by 2: prescale 0 with selector code 0 gives one tick every 2 cycles, starting in the second cycle after reset is released.
- R2: A write with select 0 loads the prescaler register. Data bits [7:0] set the prescaler for channels 0 and 1, and data bits [15:8] set the prescaler for channels 2, 3 and 4.
- R3: A prescale value P produces one prescaler pulse every P+1 base clock cycles.
- R4: A write with select 1 loads the selector register, where channel c owns data bits [4c+3:4c]. A code k that is not an external code divides the prescaler pulses by 2^(k+1). Code 0 divides by 2 and code 3 divides by 16.
- R5: A divider code whose exponent k+1 exceeds 4, and which is not an external code, divides by 16. Examples are codes 5 to 15.
- R6: Code 4 selects the external tick input. Channels 0 and 1 use external input 0, and channels 2 to 4 use external input 1. Each rising edge of that input gives exactly one single-cycle tick, and a level held high gives no further ticks. The tick appears in the third cycle counted from the cycle in which the input first goes high, after two synchronizing flops.
- R7: A write with select 0 restarts both prescalers and all dividers. A write with select 1 restarts only the dividers. After a prescaler write, the first tick on a divided channel comes (P+1)*2^(k+1) cycles after the write cycle.
- R8: No channel issues a tick in a cycle in which a configuration write is accepted. This applies to external channels as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the configuration registers |
| cfgWrSel | input | 1 | Register select: 0 for the prescaler register, 1 for the selector register |
| cfgWrData | input | 20 | Write data |
| extTickIn | input | 2 | Asynchronous external tick inputs: bit 0 for group 0, bit 1 for group 1 |
| tickOut | output | 5 | One single-cycle tick enable per channel |

## Verification
The hardest case to reach is a configuration write that lands exactly on the cycle in which a tick would otherwise fire. The interplay between a selector write, which clears only the dividers, and a prescaler that keeps its phase is also difficult. The bench reaches both by holding the write strobe high across many consecutive cycles. It also issues prescaler and selector writes back to back at a nonzero prescale, so that writes fall on prescaler pulses. A behavioural model tracks the prescaler phase and the divider counts and predicts every cycle. External-input edges are driven as long held levels and as short trains, so that edge-only triggering is confirmed both while a channel sits on an external code and while its neighbour does not.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  // Strobes from the register control to the counter datapath.
  typedef struct packed {
    logic clrPre;  // restart both prescaler counters
    logic clrDiv;  // restart every divider counter and mute ticks this cycle
  } tick_strobe_t;

  localparam int NUM_GRP = 2;
endpackage

// File: rtl/tick_cfg_ctrl.sv
module tick_cfg_ctrl
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PRE_W = 8,
  parameter int MUX_W = 4,
  parameter int DIV_W = 4,
  parameter int DIV_BASE = 1,
  parameter logic [(1<<MUX_W)-1:0] EXT_MASK = 16'h0010,
  parameter int WR_W = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrSel,
  input  logic [WR_W-1:0] wrData,
  output tick_strobe_t strobe,
  output logic [NUM_GRP-1:0][PRE_W-1:0] preVal,
  output logic [NUM_CH-1:0][DIV_W-1:0] divLim,
  output logic [NUM_CH-1:0] extSel
);
  localparam int PREREG_W = NUM_GRP * PRE_W;
  localparam int MUXREG_W = NUM_CH * MUX_W;

  logic [PREREG_W-1:0] preReg;
  logic [MUXREG_W-1:0] muxReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preReg <= '0;
      muxReg <= '0;
    end else if (wrEn) begin
      if (!wrSel) preReg <= wrData[PREREG_W-1:0];
      else        muxReg <= wrData[MUXREG_W-1:0];
    end
  end

  always_comb begin
    strobe.clrPre = wrEn & ~wrSel;
    strobe.clrDiv = wrEn;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    assign preVal[g] = preReg[g*PRE_W +: PRE_W];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic [MUX_W-1:0] code;
    logic [MUX_W:0] expo;
    logic [MUX_W:0] expoSat;
    assign code    = muxReg[c*MUX_W +: MUX_W];
    assign expo    = {1'b0, code} + (MUX_W+1)'(DIV_BASE);
    assign expoSat = (expo > (MUX_W+1)'(DIV_W)) ? (MUX_W+1)'(DIV_W) : expo;
    assign divLim[c] = ~({DIV_W{1'b1}} << expoSat);
    assign extSel[c] = EXT_MASK[code];
  end

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (preReg == $past(wrData[PREREG_W-1:0])));
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PRE_W = 8,
  parameter int DIV_W = 4,
  parameter int G0_CH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  tick_strobe_t strobe,
  input  logic [NUM_GRP-1:0][PRE_W-1:0] preVal,
  input  logic [NUM_CH-1:0][DIV_W-1:0] divLim,
  input  logic [NUM_CH-1:0] extSel,
  input  logic [NUM_GRP-1:0] extIn,
  output logic [NUM_CH-1:0] tick
);
  logic [NUM_GRP-1:0] preTick;
  logic [NUM_GRP-1:0] syncA, syncB, syncPrev;
  logic [NUM_GRP-1:0] extEdge;

  // Two-flop synchronizer followed by a rising-edge detector.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncPrev <= '0;
    end else begin
      syncA <= extIn;
      syncB <= syncA;
      syncPrev <= syncB;
    end
  end
  assign extEdge = syncB & ~syncPrev;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    logic [PRE_W-1:0] cnt;
    assign preTick[g] = (cnt == preVal[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cnt <= '0;
      else if (strobe.clrPre) cnt <= '0;
      else if (preTick[g])    cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= preVal[g]);

    // R6
    ext_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      extEdge[g] |=> !extEdge[g]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_div
    localparam int GRP = (c < G0_CH) ? 0 : 1;
    logic [DIV_W-1:0] cnt;
    logic wrap;
    assign wrap = (cnt == divLim[c]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cnt <= '0;
      else if (strobe.clrDiv) cnt <= '0;
      else if (preTick[GRP])  cnt <= wrap ? '0 : cnt + 1'b1;
    end
    assign tick[c] = ~strobe.clrDiv &
                     (extSel[c] ? extEdge[GRP] : (preTick[GRP] & wrap));

    // R7
    div_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrDiv |=> (cnt == '0));
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PRE_W = 8,
  parameter int MUX_W = 4,
  parameter int DIV_W = 4,
  parameter int DIV_BASE = 1,
  parameter int G0_CH = 2,
  parameter logic [(1<<MUX_W)-1:0] EXT_MASK = 16'h0010,
  parameter int WR_W = (NUM_GRP*PRE_W > NUM_CH*MUX_W) ? NUM_GRP*PRE_W : NUM_CH*MUX_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWrEn,
  input  logic cfgWrSel,
  input  logic [WR_W-1:0] cfgWrData,
  input  logic [NUM_GRP-1:0] extTickIn,
  output logic [NUM_CH-1:0] tickOut
);
  tick_strobe_t strobe;
  logic [NUM_GRP-1:0][PRE_W-1:0] preVal;
  logic [NUM_CH-1:0][DIV_W-1:0] divLim;
  logic [NUM_CH-1:0] extSel;

  tick_cfg_ctrl #(
    .NUM_CH(NUM_CH), .PRE_W(PRE_W), .MUX_W(MUX_W), .DIV_W(DIV_W),
    .DIV_BASE(DIV_BASE), .EXT_MASK(EXT_MASK), .WR_W(WR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrSel(cfgWrSel),
    .wrData(cfgWrData), .strobe(strobe), .preVal(preVal),
    .divLim(divLim), .extSel(extSel)
  );

  tick_datapath #(
    .NUM_CH(NUM_CH), .PRE_W(PRE_W), .DIV_W(DIV_W), .G0_CH(G0_CH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preVal(preVal),
    .divLim(divLim), .extSel(extSel), .extIn(extTickIn), .tick(tickOut)
  );
endmodule

// File: tb/pwm_tick_gen_bench.sv
`timescale 1ns/100ps
module pwm_tick_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [19:0] wrData = '0;
  logic [1:0] extIn = '0;
  logic [4:0] tick;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  string curReq = "R1";
  int winCnt [5];

  // Behavioural reference state
  int mPre [2];
  int mPreCnt [2];
  int mCode [5];
  int mDiv [5];
  bit mS1 [2];
  bit mS2 [2];
  bit mPrev [2];

  always #2.5 clk = ~clk;

  pwm_tick_gen u_pwm_tick_gen (
    .clk(clk), .rstN(rstN), .cfgWrEn(wrEn), .cfgWrSel(wrSel),
    .cfgWrData(wrData), .extTickIn(extIn), .tickOut(tick)
  );

  function automatic int grpOf(int c);
    return (c < 2) ? 0 : 1;
  endfunction

  function automatic int limOf(int code);
    int d;
    d = code + 1;
    if (d > 4) d = 4;
    return (1 << d) - 1;
  endfunction

  function automatic bit expBit(int c);
    int g;
    g = grpOf(c);
    if (wrEn) return 1'b0;
    if (mCode[c] == 4) return mS2[g] && !mPrev[g];
    return (mPreCnt[g] == mPre[g]) && (mDiv[c] == limOf(mCode[c]));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mPre[i] = 0; mPreCnt[i] = 0; mS1[i] = 0; mS2[i] = 0; mPrev[i] = 0;
      end
      for (int i = 0; i < 5; i++) begin
        mCode[i] = 0; mDiv[i] = 0;
      end
    end else begin
      bit pt [2];
      for (int g = 0; g < 2; g++) pt[g] = (mPreCnt[g] == mPre[g]);
      for (int c = 0; c < 5; c++) begin
        if (wrEn) mDiv[c] = 0;
        else if (pt[grpOf(c)]) mDiv[c] = (mDiv[c] == limOf(mCode[c])) ? 0 : mDiv[c] + 1;
      end
      for (int g = 0; g < 2; g++) begin
        if ((wrEn && !wrSel) || pt[g]) mPreCnt[g] = 0;
        else mPreCnt[g] = mPreCnt[g] + 1;
        mPrev[g] = mS2[g];
        mS2[g] = mS1[g];
        mS1[g] = extIn[g];
      end
      if (wrEn && !wrSel) begin
        mPre[0] = int'(wrData[7:0]);
        mPre[1] = int'(wrData[15:8]);
      end else if (wrEn) begin
        for (int c = 0; c < 5; c++) mCode[c] = int'(wrData[c*4 +: 4]);
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [4:0] e;
      for (int c = 0; c < 5; c++) e[c] = expBit(c);
      check(tick == e, curReq, int'(tick), int'(e));
    end
  end

  task automatic writeCfg(input bit sel, input logic [19:0] data);
    @(posedge clk); #1;
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic countWin(input int cycles);
    for (int i = 0; i < 5; i++) winCnt[i] = 0;
    repeat (cycles) begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) winCnt[i] += int'(tick[i]);
    end
  endtask

  task automatic firstTick(input int ch, input string req, input int exp);
    int n;
    n = 0;
    while (n < 1000) begin
      @(negedge clk);
      n++;
      if (tick[ch]) break;
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic expectWin(input string req, input int e0, input int e1,
                           input int e2, input int e3, input int e4);
    int e [5];
    e = '{e0, e1, e2, e3, e4};
    for (int i = 0; i < 5; i++) check(winCnt[i] == e[i], req, winCnt[i], e[i]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tick == 5'b0, "R1", int'(tick), 0);
    @(posedge clk); #1 rstN = 1'b1;
    countWin(20);
    expectWin("R1", 10, 10, 10, 10, 10);

    // R2 R3 field layout and prescale
    curReq = "R3";
    writeCfg(1'b0, 20'h00402);
    countWin(60);
    expectWin("R2", 10, 10, 6, 6, 6);

    // R7 first tick after a prescaler write
    curReq = "R7";
    writeCfg(1'b0, 20'h00402);
    firstTick(0, "R7", 6);
    writeCfg(1'b0, 20'h00402);
    firstTick(2, "R7", 10);
    writeCfg(1'b0, 20'h00001);
    writeCfg(1'b1, 20'h00000);
    countWin(40);

    // R4 R5 divider codes
    curReq = "R4";
    writeCfg(1'b0, 20'h00000);
    writeCfg(1'b1, 20'h07231);
    countWin(160);
    expectWin("R4", 40, 10, 20, 10, 80);
    curReq = "R5";
    writeCfg(1'b1, 20'hF7231);
    firstTick(4, "R5", 16);

    // R6 external ticks
    curReq = "R6";
    writeCfg(1'b1, 20'h04004);
    @(posedge clk); #1 extIn[0] = 1'b1;
    firstTick(0, "R6", 3);
    countWin(12);
    check(winCnt[0] == 0, "R6", winCnt[0], 0);
    @(posedge clk); #1 extIn[0] = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    fork
      countWin(24);
      begin
        extIn[1] = 1'b1; repeat (3) @(posedge clk); #1;
        extIn[1] = 1'b0; repeat (3) @(posedge clk); #1;
        extIn[1] = 1'b1; repeat (3) @(posedge clk); #1;
        extIn[1] = 1'b0;
      end
    join
    expectWin("R6", 0, winCnt[1], winCnt[2], 2, 12);
    check(winCnt[1] == 12, "R6", winCnt[1], 12);

    // R8 continuous writes mute every channel
    curReq = "R8";
    @(posedge clk); #1;
    wrEn = 1'b1; wrSel = 1'b1; wrData = 20'h04004;
    fork
      countWin(10);
      begin
        repeat (4) @(posedge clk); #1 extIn[1] = 1'b1;
      end
    join
    expectWin("R8", 0, 0, 0, 0, 0);
    @(posedge clk); #1 wrEn = 1'b0;
    countWin(10);
    check(winCnt[1] == 5, "R8", winCnt[1], 5);

    done = 1;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule